// File: doc/BRIEF.md
# Edge-Interrupt GPIO Port Controller

A sixteen-line general-purpose port for a chip's peripheral region. Each line is set by software as an input or an output. An output line drives the value held in a software-written output register. An input line is sampled through a two-stage synchronizer and can flag an interrupt on one chosen transition: rising or falling, picked line by line.

Captured transitions are held in a sticky status register, and the single interrupt output stays high while any status bit is set. Software clears status bits by writing ones to them. The mask only decides whether a transition is captured. A bit that is already captured keeps the interrupt raised even if its line is masked afterwards. A pin-enable register gates which synchronized input values are visible when the input register is read.

The register bus is synchronous. A write takes effect at the clock edge where the write enable is high. Read data is combinational during a cycle where the read enable is high and is zero in every other cycle. Only 16-bit accesses (size code 2'b01) do anything.

Top module: `gpio_edge_port`

## Requirements
- R1: After reset the registers read: output data 0xFFFF, direction 0xFFFF, edge select 0xFFFF, mask 0xFFFF, status 0x0000, pin enable 0xFFFF, input data 0x0000. After reset padOe is 0x0000, padOut is 0x0000 and irqOut is 0.
- R2: Byte offsets: 0x00 input data (read-only), 0x04 output data, 0x08 direction, 0x0C edge select, 0x10 mask, 0x14 status, 0x18 pin enable. A valid write to offset 0x04, 0x08, 0x0C, 0x10 or 0x18 is read back unchanged at the same offset.
- R3: Direction bit 1 makes a line an input and bit 0 makes it an output. padOe equals the inverse of the direction register. padOut carries the output-data bit on output lines and 0 on input lines.
- R4: Edge-select bit 1 captures a low-to-high transition and bit 0 captures a high-to-low transition. The opposite transition is not captured. A captured transition shows in the status register no later than the third rising clock edge after the pad changes.
- R5: A transition sets its status bit only when the line's direction bit is 1 and its mask bit is 0.
- R6: Writing the status register clears each bit written as 1. irqOut is high whenever any status bit is set and low when all are zero. Setting a mask bit after a capture neither clears the status bit nor lowers irqOut.
- R7: Reading the input data register returns the synchronized pad values ANDed with the pin-enable register.
- R8: An access whose size code is not 2'b01 changes no register, and a read of that kind returns 0x0000.
- R9: Writes to offset 0x00 or to any offset not listed in R2 change no register. A read of an unlisted offset returns 0x0000.
- R10: When a new transition and a status clear hit the same bit in the same cycle, the bit stays set.
- R11: A pad change is not visible in the input data register at the first rising edge after the change. It becomes visible from the second rising edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| busAddr | input | 8 | Byte offset of the access |
| busWrEn | input | 1 | Write strobe |
| busRdEn | input | 1 | Read strobe |
| busSize | input | 2 | Access size code, 2'b01 = 16-bit |
| busWdata | input | 16 | Write data |
| busRdata | output | 16 | Read data, zero when no valid read is active |
| padIn | input | 16 | External input levels |
| padOut | output | 16 | Output levels |
| padOe | output | 16 | Per-line output enables |
| irqOut | output | 1 | Summary interrupt, level |

## Verification
The hardest case to reach from the ports is a new transition arriving in exactly the same cycle as a status clear for the same bit. The pad change has to go through the synchronizer and the previous-value stage, so it only reaches the status logic two clock edges after the pad moves. The stimulus therefore changes the pad at one falling clock edge and raises the status write two falling edges later, so the clear and the capture meet at the same rising edge. A plain clear that follows then shows that the bit was held by the new transition and was not simply left over from earlier.

// File: rtl/gpio_edge_pkg.sv
package gpio_edge_pkg;

  localparam logic [1:0] SIZE_HALF = 2'b01;

  typedef enum logic [2:0] {
    RD_NONE,
    RD_IN,
    RD_OUT,
    RD_DIR,
    RD_EDGE,
    RD_MASK,
    RD_STAT,
    RD_PIN
  } rdSel_e;

  typedef struct packed {
    logic   wrOut;
    logic   wrDir;
    logic   wrEdge;
    logic   wrMask;
    logic   wrStat;
    logic   wrPin;
    rdSel_e rdSel;
  } ctlStrb_t;

endpackage

// File: rtl/gpio_edge_ctrl.sv
module gpio_edge_ctrl
  import gpio_edge_pkg::*;
#(
  parameter int ADDR_W = 8
) (
  input  logic [ADDR_W-1:0] busAddr,
  input  logic              busWrEn,
  input  logic              busRdEn,
  input  logic [1:0]        busSize,
  output ctlStrb_t          strb
);

  localparam logic [ADDR_W-1:0] OFF_IN   = ADDR_W'(8'h00);
  localparam logic [ADDR_W-1:0] OFF_OUT  = ADDR_W'(8'h04);
  localparam logic [ADDR_W-1:0] OFF_DIR  = ADDR_W'(8'h08);
  localparam logic [ADDR_W-1:0] OFF_EDGE = ADDR_W'(8'h0C);
  localparam logic [ADDR_W-1:0] OFF_MASK = ADDR_W'(8'h10);
  localparam logic [ADDR_W-1:0] OFF_STAT = ADDR_W'(8'h14);
  localparam logic [ADDR_W-1:0] OFF_PIN  = ADDR_W'(8'h18);

  logic sizeOk;
  logic wrGo;
  logic rdGo;

  assign sizeOk = (busSize == SIZE_HALF);
  assign wrGo   = busWrEn && sizeOk;
  assign rdGo   = busRdEn && sizeOk;

  always_comb begin
    strb = '0;
    strb.rdSel = RD_NONE;
    if (wrGo) begin
      unique case (busAddr)
        OFF_OUT:  strb.wrOut  = 1'b1;
        OFF_DIR:  strb.wrDir  = 1'b1;
        OFF_EDGE: strb.wrEdge = 1'b1;
        OFF_MASK: strb.wrMask = 1'b1;
        OFF_STAT: strb.wrStat = 1'b1;
        OFF_PIN:  strb.wrPin  = 1'b1;
        default:  ;
      endcase
    end
    if (rdGo) begin
      unique case (busAddr)
        OFF_IN:   strb.rdSel = RD_IN;
        OFF_OUT:  strb.rdSel = RD_OUT;
        OFF_DIR:  strb.rdSel = RD_DIR;
        OFF_EDGE: strb.rdSel = RD_EDGE;
        OFF_MASK: strb.rdSel = RD_MASK;
        OFF_STAT: strb.rdSel = RD_STAT;
        OFF_PIN:  strb.rdSel = RD_PIN;
        default:  strb.rdSel = RD_NONE;
      endcase
    end
  end

endmodule

// File: rtl/gpio_edge_dpath.sv
module gpio_edge_dpath
  import gpio_edge_pkg::*;
#(
  parameter int LINES = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  ctlStrb_t         strb,
  input  logic [LINES-1:0] busWdata,
  input  logic [LINES-1:0] padIn,
  output logic [LINES-1:0] rdData,
  output logic [LINES-1:0] padOut,
  output logic [LINES-1:0] padOe,
  output logic             irqOut
);

  logic [LINES-1:0] metaS, syncS, prevS;
  logic [LINES-1:0] outReg, dirReg, edgeReg, maskReg, statReg, pinReg;
  logic [LINES-1:0] edgeHit;
  logic [LINES-1:0] clrBits;

  // Two-flop synchronizer plus previous-value stage
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      metaS <= '0;
      syncS <= '0;
      prevS <= '0;
    end else begin
      metaS <= padIn;
      syncS <= metaS;
      prevS <= syncS;
    end
  end

  // Per-line transition detect with selectable polarity
  for (genvar i = 0; i < LINES; i++) begin : g_line
    logic riseI, fallI;
    assign riseI = syncS[i] & ~prevS[i];
    assign fallI = ~syncS[i] & prevS[i];
    assign edgeHit[i] = (edgeReg[i] ? riseI : fallI) & dirReg[i] & ~maskReg[i];
  end

  assign clrBits = strb.wrStat ? busWdata : '0;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      outReg  <= '1;
      dirReg  <= '1;
      edgeReg <= '1;
      maskReg <= '1;
      statReg <= '0;
      pinReg  <= '1;
    end else begin
      if (strb.wrOut)  outReg  <= busWdata;
      if (strb.wrDir)  dirReg  <= busWdata;
      if (strb.wrEdge) edgeReg <= busWdata;
      if (strb.wrMask) maskReg <= busWdata;
      if (strb.wrPin)  pinReg  <= busWdata;
      statReg <= (statReg & ~clrBits) | edgeHit;
    end
  end

  always_comb begin
    unique case (strb.rdSel)
      RD_IN:   rdData = syncS & pinReg;
      RD_OUT:  rdData = outReg;
      RD_DIR:  rdData = dirReg;
      RD_EDGE: rdData = edgeReg;
      RD_MASK: rdData = maskReg;
      RD_STAT: rdData = statReg;
      RD_PIN:  rdData = pinReg;
      default: rdData = '0;
    endcase
  end

  assign padOe  = ~dirReg;
  assign padOut = outReg & ~dirReg;
  assign irqOut = |statReg;

  AST_MASKED_NO_CAPTURE: assert property (@(posedge clk) disable iff (!rst_n)
    ((statReg & ~$past(statReg)) & $past(~dirReg | maskReg)) == '0); // R5

  AST_W1C_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
    (strb.wrStat && edgeHit == '0) |=> ((statReg & $past(busWdata)) == '0)); // R6

  AST_EDGE_WINS: assert property (@(posedge clk) disable iff (!rst_n)
    (edgeHit != '0) |=> ((statReg & $past(edgeHit)) == $past(edgeHit))); // R10

  AST_DIR_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    !strb.wrDir |=> $stable(dirReg)); // R8

endmodule

// File: rtl/gpio_edge_port.sv
module gpio_edge_port
  import gpio_edge_pkg::*;
#(
  parameter int LINES  = 16,
  parameter int ADDR_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [ADDR_W-1:0] busAddr,
  input  logic              busWrEn,
  input  logic              busRdEn,
  input  logic [1:0]        busSize,
  input  logic [LINES-1:0]  busWdata,
  output logic [LINES-1:0]  busRdata,
  input  logic [LINES-1:0]  padIn,
  output logic [LINES-1:0]  padOut,
  output logic [LINES-1:0]  padOe,
  output logic              irqOut
);

  ctlStrb_t strb;

  gpio_edge_ctrl #(.ADDR_W(ADDR_W)) ctrl_i (
    .busAddr (busAddr),
    .busWrEn (busWrEn),
    .busRdEn (busRdEn),
    .busSize (busSize),
    .strb    (strb)
  );

  gpio_edge_dpath #(.LINES(LINES)) dpath_i (
    .clk      (clk),
    .rst_n    (rst_n),
    .strb     (strb),
    .busWdata (busWdata),
    .padIn    (padIn),
    .rdData   (busRdata),
    .padOut   (padOut),
    .padOe    (padOe),
    .irqOut   (irqOut)
  );

  AST_BAD_SIZE_READS_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    (busRdEn && busSize != SIZE_HALF) |-> busRdata == '0); // R8

  AST_IRQ_FALLS_ON_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(irqOut) |-> $past(busWrEn)); // R6

endmodule

// File: tb/gpio_edge_port_tb.sv
module gpio_edge_port_tb_top;

  localparam int CLK_PERIOD = 10;
  localparam int KIND_RD  = 0;
  localparam int KIND_OUT = 1;
  localparam int KIND_OE  = 2;
  localparam int KIND_IRQ = 3;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [7:0]  busAddr = '0;
  logic        busWrEn = 1'b0;
  logic        busRdEn = 1'b0;
  logic [1:0]  busSize = 2'b01;
  logic [15:0] busWdata = '0;
  logic [15:0] busRdata;
  logic [15:0] padIn = '0;
  logic [15:0] padOut;
  logic [15:0] padOe;
  logic        irqOut;

  int          nChecks = 0;
  int          nFails = 0;
  bit          finished = 1'b0;

  int          kindQ[$];
  logic [15:0] expQ[$];
  string       tagQ[$];

  always #(CLK_PERIOD/2) clk = ~clk;

  gpio_edge_port dut_i (
    .clk(clk), .rst_n(rst_n), .busAddr(busAddr), .busWrEn(busWrEn),
    .busRdEn(busRdEn), .busSize(busSize), .busWdata(busWdata),
    .busRdata(busRdata), .padIn(padIn), .padOut(padOut), .padOe(padOe),
    .irqOut(irqOut)
  );

  // Monitor: pops expectations one ns after each rising edge
  initial begin
    forever begin
      @(posedge clk);
      #1;
      while (kindQ.size() > 0) begin
        int k;
        logic [15:0] e, a;
        string t;
        k = kindQ.pop_front();
        e = expQ.pop_front();
        t = tagQ.pop_front();
        case (k)
          KIND_RD:  a = busRdata;
          KIND_OUT: a = padOut;
          KIND_OE:  a = padOe;
          default:  a = {15'b0, irqOut};
        endcase
        nChecks++;
        if (a !== e) begin
          nFails++;
          $display("FAIL %s actual=%h expected=%h", t, a, e);
        end
      end
    end
  end

  task automatic pushExp(input int k, input logic [15:0] e, input string t);
    kindQ.push_back(k);
    expQ.push_back(e);
    tagQ.push_back(t);
  endtask

  task automatic busWrite(input logic [7:0] a, input logic [15:0] d,
                          input logic [1:0] sz = 2'b01);
    @(negedge clk);
    busAddr = a; busWdata = d; busSize = sz; busWrEn = 1'b1;
    @(negedge clk);
    busWrEn = 1'b0; busSize = 2'b01;
  endtask

  task automatic busRead(input logic [7:0] a, input logic [15:0] e,
                         input string t, input logic [1:0] sz = 2'b01);
    @(negedge clk);
    busAddr = a; busSize = sz; busRdEn = 1'b1;
    pushExp(KIND_RD, e, t);
    @(posedge clk);
    #2;
    busRdEn = 1'b0; busSize = 2'b01;
  endtask

  task automatic expectPin(input int k, input logic [15:0] e, input string t);
    @(negedge clk);
    pushExp(k, e, t);
    @(posedge clk);
    #2;
  endtask

  task automatic setPad(input logic [15:0] v);
    @(negedge clk);
    padIn = v;
    repeat (4) @(negedge clk);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!finished) begin
      nFails++;
      $display("FAIL watchdog expired");
      $display("  == %0d vectors applied, %0d miscompares ==", nChecks, nFails);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;

    // R1 reset state
    busRead(8'h00, 16'h0000, "R1 input data");
    busRead(8'h04, 16'hFFFF, "R1 output data");
    busRead(8'h08, 16'hFFFF, "R1 direction");
    busRead(8'h0C, 16'hFFFF, "R1 edge select");
    busRead(8'h10, 16'hFFFF, "R1 mask");
    busRead(8'h14, 16'h0000, "R1 status");
    busRead(8'h18, 16'hFFFF, "R1 pin enable");
    expectPin(KIND_OE, 16'h0000, "R1 padOe");
    expectPin(KIND_OUT, 16'h0000, "R1 padOut");
    expectPin(KIND_IRQ, 16'h0000, "R1 irq");

    // R2, R3 read-back and output drive
    busWrite(8'h04, 16'hA5C3);
    busWrite(8'h08, 16'h00FF);
    busRead(8'h04, 16'hA5C3, "R2 output data readback");
    busRead(8'h08, 16'h00FF, "R2 direction readback");
    expectPin(KIND_OE, 16'hFF00, "R3 padOe");
    expectPin(KIND_OUT, 16'hA500, "R3 padOut");

    // R8 bad access size
    busWrite(8'h08, 16'h1234, 2'b10);
    busWrite(8'h04, 16'h0000, 2'b00);
    busRead(8'h08, 16'h00FF, "R8 direction after wide write");
    busRead(8'h04, 16'hA5C3, "R8 output after byte write");
    busRead(8'h08, 16'h0000, "R8 byte read returns zero", 2'b00);

    // R9 read-only and undefined offsets
    busWrite(8'h00, 16'h1234);
    busWrite(8'h1C, 16'h5A5A);
    busRead(8'h00, 16'h0000, "R9 input data after write");
    busRead(8'h1C, 16'h0000, "R9 undefined offset reads zero");
    busRead(8'h04, 16'hA5C3, "R9 output unchanged");
    busRead(8'h0C, 16'hFFFF, "R9 edge unchanged");

    // R11 synchronizer latency
    @(negedge clk);
    padIn = 16'h0055;
    busAddr = 8'h00; busRdEn = 1'b1;
    pushExp(KIND_RD, 16'h0000, "R11 not yet visible");
    @(posedge clk);
    #2;
    busRdEn = 1'b0;
    busRead(8'h00, 16'h0055, "R11 visible after second edge");

    // R7 pin enable gating
    busWrite(8'h18, 16'h000F);
    busRead(8'h00, 16'h0005, "R7 gated input read");
    busWrite(8'h18, 16'hFFFF);

    // Edge capture setup: lines 4,5 rising, 6,7 falling, unmask 4..7
    busWrite(8'h0C, 16'h0030);
    busWrite(8'h10, 16'hFF0F);
    busRead(8'h14, 16'h0000, "R5 no capture from config writes");

    setPad(16'h0075);
    busRead(8'h14, 16'h0020, "R4 rising capture line 5");
    expectPin(KIND_IRQ, 16'h0001, "R6 irq high");
    setPad(16'h0035);
    busRead(8'h14, 16'h0060, "R4 falling capture line 6");
    setPad(16'h0025);
    busRead(8'h14, 16'h0060, "R4 wrong polarity ignored line 4");
    setPad(16'h0024);
    busRead(8'h14, 16'h0060, "R5 masked line 0 ignored");

    // R5 output line ignored even when unmasked
    busWrite(8'h10, 16'hFE0F);
    setPad(16'h0125);
    setPad(16'h0025);
    busRead(8'h14, 16'h0060, "R5 output line 8 ignored");

    // R6 mask after capture, then write-one-to-clear
    busWrite(8'h10, 16'hFFFF);
    busRead(8'h14, 16'h0060, "R6 status kept after masking");
    expectPin(KIND_IRQ, 16'h0001, "R6 irq kept after masking");
    busWrite(8'h14, 16'h0020);
    busRead(8'h14, 16'h0040, "R6 partial clear");
    expectPin(KIND_IRQ, 16'h0001, "R6 irq still high");
    busWrite(8'h14, 16'h0040);
    busRead(8'h14, 16'h0000, "R6 full clear");
    expectPin(KIND_IRQ, 16'h0000, "R6 irq low");

    // R10 capture and clear in the same cycle
    busWrite(8'h10, 16'hFFDF);
    setPad(16'h0005);
    setPad(16'h0025);
    busRead(8'h14, 16'h0020, "R10 prior capture");
    setPad(16'h0005);
    @(negedge clk);
    padIn = 16'h0025;
    @(negedge clk);
    @(negedge clk);
    busAddr = 8'h14; busWdata = 16'h0020; busWrEn = 1'b1;
    @(negedge clk);
    busWrEn = 1'b0;
    busRead(8'h14, 16'h0020, "R10 new edge beats clear");
    busWrite(8'h14, 16'h0020);
    busRead(8'h14, 16'h0000, "R10 later clear succeeds");

    repeat (3) @(negedge clk);
    finished = 1'b1;
    $display("  == %0d vectors applied, %0d miscompares ==", nChecks, nFails);
    $finish;
  end

endmodule